// File: doc/BRIEF.md
# Completion Ring Posting Engine

This block is the producer half of a circular completion ring that lives in host memory. Finished command records arrive on a valid/ready port and wait in a small pending FIFO. For each record the engine computes the host write address from the ring base and its tail index. It then builds a 16-byte completion entry stamped with the current phase tag and presents it as a memory write request. The tail moves forward only when the memory side acknowledges the write.

The consumer head index comes in from a separate doorbell block. The engine compares it with its own tail, and while the ring is full it holds every pending record back. When a run of postings ends, because the FIFO has drained or the ring has filled, the engine raises one interrupt request. It uses a message interrupt on the configured vector or a legacy pulse, as configured. A synchronous reset or a queue-delete strobe returns the engine to its initial state.

The control state machine has four states:
- `S_IDLE`: waiting. It goes to `S_WRITE` when a record is pending and the ring is not full.
- `S_WRITE`: the write request is held. It goes to `S_CHECK` on acknowledge.
- `S_CHECK`: it goes back to `S_WRITE` if another record is pending and the ring still has room. Otherwise it goes to `S_NOTIFY`.
- `S_NOTIFY`: a one-cycle interrupt slot. It always goes to `S_IDLE`.

Reset and delete force `S_IDLE`.

Top module: `cq_post_engine`

## Requirements
- R1: After reset or a `del_q` strobe, the tail index is 0 and the phase tag is 1, so the next entry is written to `cfg_base` with phase bit 1. `wr_req`, `msi_req` and `intx_pulse` are low, and `in_ready` is high.
- R2: The write address equals `cfg_base + (tail << cfg_esz_exp)`, where the entry size is 2 to the power `cfg_esz_exp` bytes (16 bytes for an exponent of 4).
- R3: The 128-bit `wr_data` has the following layout:
  - bits 31:0 carry the result;
  - bits 63:32 are zero;
  - bits 79:64 carry the submission queue head;
  - bits 95:80 carry the submission queue id;
  - bits 111:96 carry the command id;
  - bits 127:112 carry the status word, which is the 15-bit completion status shifted left by one with the phase tag in bit 112.
- R4: While `wr_req` is high and `wr_ack` is low, `wr_req`, `wr_addr` and `wr_data` hold steady. The tail advances once per acknowledged write and never without an acknowledge.
- R5: The ring holds `cfg_qsize + 1` entries. When the tail advances past index `cfg_qsize` it returns to 0 and the phase tag inverts.
- R6: The ring is full when the index after the tail (modulo the ring size) equals `cons_head`. No write starts while the ring is full, and pending records stay queued until the head moves.
- R7: After each run of postings, the engine acts on the interrupt settings in one cycle:
  - if `cfg_irq_en` and `cfg_msi_en` are both high, it raises `msi_req` with `msi_vector = cfg_vector`;
  - if `cfg_irq_en` is high and `cfg_msi_en` is low, it raises `intx_pulse`;
  - if `cfg_irq_en` is low, it raises neither.
- R8: Records are posted in arrival order. `in_ready` is low exactly when `FIFO_DEPTH` records are pending.
- R9: A `del_q` strobe discards all pending records, so none of them is ever written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| del_q | input | 1 | Queue-delete strobe, clears all state |
| cfg_base | input | 64 | Ring base address in host memory |
| cfg_qsize | input | QW | Zero-based ring size |
| cfg_esz_exp | input | 4 | Log2 of the entry size in bytes |
| cfg_irq_en | input | 1 | Interrupts enabled for this ring |
| cfg_msi_en | input | 1 | Message interrupts selected |
| cfg_vector | input | VW | Message interrupt vector |
| cons_head | input | QW | Consumer head index from the doorbell block |
| in_valid | input | 1 | Completion record valid |
| in_ready | output | 1 | Pending FIFO can accept a record |
| in_cid | input | 16 | Command id |
| in_sqid | input | 16 | Originating submission queue id |
| in_sqhd | input | 16 | Submission queue head index |
| in_status | input | 15 | Completion status |
| in_result | input | 32 | Command result value |
| wr_req | output | 1 | Memory write request |
| wr_ack | input | 1 | Memory write acknowledge |
| wr_addr | output | 64 | Write address |
| wr_data | output | 128 | Completion entry |
| msi_req | output | 1 | Message interrupt request, one cycle |
| msi_vector | output | VW | Vector for `msi_req` |
| intx_pulse | output | 1 | Legacy interrupt pulse, one cycle |

## Verification
The assertions rest on four assumptions about the inputs:
- `wr_ack` is raised only while `wr_req` is high.
- `cons_head` never exceeds `cfg_qsize`, and it moves only toward the tail.
- The ring configuration stays constant between deletes.
- Reset and delete are the only times the checker's own tail and phase model restarts.

The bench keeps within these by acknowledging only a request it has already seen and by setting the head only to an index the ring has already filled. It changes the base and the entry size only around a `del_q` strobe.

// File: rtl/cqp_pkg.sv
package cqp_pkg;
    localparam int FIELD_W  = 16;
    localparam int STAT_W   = 15;
    localparam int RES_W    = 32;
    localparam int ENTRY_W  = 128;

    typedef struct packed {
        logic [FIELD_W-1:0] cid;
        logic [FIELD_W-1:0] sqid;
        logic [FIELD_W-1:0] sqhd;
        logic [STAT_W-1:0]  status;
        logic [RES_W-1:0]   result;
    } cqp_rec_t;

    localparam int REC_W = $bits(cqp_rec_t);

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_WRITE  = 2'd1,
        S_CHECK  = 2'd2,
        S_NOTIFY = 2'd3
    } cqp_state_t;
endpackage

// File: rtl/cqp_fifo.sv
module cqp_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;

    assign empty = (wp == rp);
    assign full  = (wp[AW-1:0] == rp[AW-1:0]) && (wp[AW] != rp[AW]);
    assign dout  = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) begin
                mem[wp[AW-1:0]] <= din;
                wp <= wp + 1'b1;
            end
            if (pop && !empty) begin
                rp <= rp + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cqp_ring.sv
module cqp_ring #(
    parameter int QW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          adv,
    input  logic [QW-1:0] qsize,
    input  logic [QW-1:0] head,
    output logic [QW-1:0] tail,
    output logic          phase,
    output logic          full
);
    logic          at_end;
    logic [QW-1:0] nxt;

    assign at_end = (tail == qsize);
    assign nxt    = at_end ? '0 : tail + 1'b1;
    assign full   = (nxt == head);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tail  <= '0;
            phase <= 1'b1;
        end else if (adv) begin
            tail <= nxt;
            if (at_end) begin
                phase <= ~phase;
            end
        end
    end
endmodule

// File: rtl/cqp_entry_fmt.sv
module cqp_entry_fmt
    import cqp_pkg::*;
#(
    parameter int QW = 12
) (
    input  cqp_rec_t             rec,
    input  logic                 phase,
    input  logic [QW-1:0]        tail,
    input  logic [63:0]          base,
    input  logic [3:0]           esz_exp,
    output logic [63:0]          addr,
    output logic [ENTRY_W-1:0]   data
);
    logic [63:0] offset;

    always_comb begin
        offset = 64'(tail) << esz_exp;
        addr   = base + offset;
        data   = {rec.status, phase, rec.cid, rec.sqid, rec.sqhd,
                  32'h0, rec.result};
    end
endmodule

// File: rtl/cq_post_engine.sv
module cq_post_engine
    import cqp_pkg::*;
#(
    parameter int QW         = 12,
    parameter int VW         = 6,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 del_q,
    input  logic [63:0]          cfg_base,
    input  logic [QW-1:0]        cfg_qsize,
    input  logic [3:0]           cfg_esz_exp,
    input  logic                 cfg_irq_en,
    input  logic                 cfg_msi_en,
    input  logic [VW-1:0]        cfg_vector,
    input  logic [QW-1:0]        cons_head,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [FIELD_W-1:0]   in_cid,
    input  logic [FIELD_W-1:0]   in_sqid,
    input  logic [FIELD_W-1:0]   in_sqhd,
    input  logic [STAT_W-1:0]    in_status,
    input  logic [RES_W-1:0]     in_result,
    output logic                 wr_req,
    input  logic                 wr_ack,
    output logic [63:0]          wr_addr,
    output logic [ENTRY_W-1:0]   wr_data,
    output logic                 msi_req,
    output logic [VW-1:0]        msi_vector,
    output logic                 intx_pulse
);
    cqp_state_t    state, state_nx;
    cqp_rec_t      in_rec, head_rec;
    logic          fifo_empty, fifo_full;
    logic          ring_full;
    logic          posted;
    logic [QW-1:0] tail;
    logic          phase;
    logic          can_post;

    assign in_rec   = '{cid: in_cid, sqid: in_sqid, sqhd: in_sqhd,
                        status: in_status, result: in_result};
    assign in_ready = !fifo_full;
    assign posted   = (state == S_WRITE) && wr_ack;
    assign can_post = !fifo_empty && !ring_full;

    cqp_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (del_q),
        .push  (in_valid),
        .din   (in_rec),
        .pop   (posted),
        .dout  (head_rec),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    cqp_ring #(.QW(QW)) u_ring (
        .clk   (clk),
        .rst   (rst),
        .clr   (del_q),
        .adv   (posted),
        .qsize (cfg_qsize),
        .head  (cons_head),
        .tail  (tail),
        .phase (phase),
        .full  (ring_full)
    );

    cqp_entry_fmt #(.QW(QW)) u_fmt (
        .rec     (head_rec),
        .phase   (phase),
        .tail    (tail),
        .base    (cfg_base),
        .esz_exp (cfg_esz_exp),
        .addr    (wr_addr),
        .data    (wr_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst || del_q) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (can_post) state_nx = S_WRITE;
            S_WRITE:  if (wr_ack)   state_nx = S_CHECK;
            S_CHECK:  state_nx = can_post ? S_WRITE : S_NOTIFY;
            S_NOTIFY: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        wr_req     = 1'b0;
        msi_req    = 1'b0;
        intx_pulse = 1'b0;
        msi_vector = cfg_vector;
        unique case (state)
            S_WRITE:  wr_req = 1'b1;
            S_NOTIFY: begin
                msi_req    = cfg_irq_en && cfg_msi_en;
                intx_pulse = cfg_irq_en && !cfg_msi_en;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cqp_chk.sv
module cqp_chk #(
    parameter int QW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          del_q,
    input logic [63:0]   cfg_base,
    input logic [QW-1:0] cfg_qsize,
    input logic [3:0]    cfg_esz_exp,
    input logic [QW-1:0] cons_head,
    input logic          wr_req,
    input logic          wr_ack,
    input logic [63:0]   wr_addr,
    input logic [127:0]  wr_data,
    input logic          msi_req,
    input logic          intx_pulse
);
    logic [QW-1:0] m_tail;
    logic          m_phase;
    logic [QW-1:0] m_next;

    assign m_next = (m_tail == cfg_qsize) ? '0 : m_tail + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || del_q) begin
            m_tail  <= '0;
            m_phase <= 1'b1;
        end else if (wr_req && wr_ack) begin
            m_tail <= m_next;
            if (m_tail == cfg_qsize) m_phase <= ~m_phase;
        end
    end

    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst || del_q)
        wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));

    // R2
    wr_addr_chk: assert property (@(posedge clk) disable iff (rst || del_q)
        wr_req |-> wr_addr == cfg_base + (64'(m_tail) << cfg_esz_exp));

    // R3
    phase_bit_chk: assert property (@(posedge clk) disable iff (rst || del_q)
        wr_req |-> wr_data[112] == m_phase);

    // R6
    no_post_full_chk: assert property (@(posedge clk) disable iff (rst || del_q)
        $rose(wr_req) |-> m_next != cons_head);

    // R7
    irq_excl_chk: assert property (@(posedge clk) disable iff (rst || del_q)
        !(msi_req && intx_pulse));

    // R7
    irq_once_chk: assert property (@(posedge clk) disable iff (rst || del_q)
        (msi_req || intx_pulse) |=> !msi_req && !intx_pulse);
endmodule

bind cq_post_engine cqp_chk #(.QW(QW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .del_q       (del_q),
    .cfg_base    (cfg_base),
    .cfg_qsize   (cfg_qsize),
    .cfg_esz_exp (cfg_esz_exp),
    .cons_head   (cons_head),
    .wr_req      (wr_req),
    .wr_ack      (wr_ack),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .msi_req     (msi_req),
    .intx_pulse  (intx_pulse)
);

// File: tb/cq_post_engine_tb.sv
module cq_post_engine_tb;
    localparam int QW = 12;
    localparam int VW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          del_q = 1'b0;
    logic [63:0]   cfg_base = 64'h0000_0001_2000_0000;
    logic [QW-1:0] cfg_qsize = 12'd3;
    logic [3:0]    cfg_esz_exp = 4'd4;
    logic          cfg_irq_en = 1'b1;
    logic          cfg_msi_en = 1'b1;
    logic [VW-1:0] cfg_vector = 6'd5;
    logic [QW-1:0] cons_head = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [15:0]   in_cid = '0, in_sqid = '0, in_sqhd = '0;
    logic [14:0]   in_status = '0;
    logic [31:0]   in_result = '0;
    logic          wr_req;
    logic          wr_ack = 1'b0;
    logic [63:0]   wr_addr;
    logic [127:0]  wr_data;
    logic          msi_req;
    logic [VW-1:0] msi_vector;
    logic          intx_pulse;

    int n_chk = 0, n_fail = 0;
    int msi_n = 0, intx_n = 0;
    logic [VW-1:0] last_vec = '0;
    int bt = 0;
    bit bph = 1'b1;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cq_post_engine #(.QW(QW), .VW(VW), .FIFO_DEPTH(4)) u_dut (
        .clk(clk), .rst(rst), .del_q(del_q),
        .cfg_base(cfg_base), .cfg_qsize(cfg_qsize), .cfg_esz_exp(cfg_esz_exp),
        .cfg_irq_en(cfg_irq_en), .cfg_msi_en(cfg_msi_en), .cfg_vector(cfg_vector),
        .cons_head(cons_head), .in_valid(in_valid), .in_ready(in_ready),
        .in_cid(in_cid), .in_sqid(in_sqid), .in_sqhd(in_sqhd),
        .in_status(in_status), .in_result(in_result),
        .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_data(wr_data),
        .msi_req(msi_req), .msi_vector(msi_vector), .intx_pulse(intx_pulse)
    );

    always @(negedge clk) begin
        if (msi_req) begin
            msi_n++;
            last_vec = msi_vector;
        end
        if (intx_pulse) intx_n++;
    end

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] cid, input logic [14:0] st,
                        input logic [31:0] res);
        in_cid = cid; in_sqid = cid ^ 16'h00A5; in_sqhd = cid + 16'd7;
        in_status = st; in_result = res; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [127:0] entry(input logic [15:0] cid,
        input logic [14:0] st, input logic [31:0] res, input bit ph);
        return {st, ph, cid, cid ^ 16'h00A5, cid + 16'd7, 32'h0, res};
    endfunction

    // Waits for a write, checks address/data, holds ack low for hold cycles.
    task automatic serve(input logic [15:0] cid, input logic [14:0] st,
                         input logic [31:0] res, input int hold, input string req);
        int w = 0;
        logic [63:0]  ea;
        logic [127:0] ed;
        ea = cfg_base + (64'(bt) << cfg_esz_exp);
        ed = entry(cid, st, res, bph);
        while (!wr_req && w < 200) begin
            @(negedge clk);
            w++;
        end
        check(wr_req, {req, " write issued"}, 128'(wr_req), 128'd1);
        if (wr_req) begin
            check(wr_addr == ea, {req, " address"}, 128'(wr_addr), 128'(ea));
            check(wr_data == ed, {req, " entry"}, wr_data, ed);
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                check(wr_req && wr_addr == ea && wr_data == ed,
                      "R4 request held until ack", wr_data, ed);
            end
            wr_ack = 1'b1;
            @(negedge clk);
            wr_ack = 1'b0;
            if (bt == int'(cfg_qsize)) begin
                bt = 0;
                bph = ~bph;
            end else begin
                bt++;
            end
        end
    endtask

    task automatic irq_expect(input int em, input int ei, input string req);
        repeat (4) @(negedge clk);
        check(msi_n == em, {req, " msi count"}, 128'(msi_n), 128'(em));
        check(intx_n == ei, {req, " intx count"}, 128'(intx_n), 128'(ei));
        msi_n = 0;
        intx_n = 0;
    endtask

    task automatic t_reset;
        check(!wr_req && !msi_req && !intx_pulse && in_ready,
              "R1 reset outputs", {wr_req, msi_req, intx_pulse, in_ready}, 128'h1);
    endtask

    task automatic t_msi_single;
        push(16'h0011, 15'h0000, 32'hCAFE_0001);
        serve(16'h0011, 15'h0000, 32'hCAFE_0001, 2, "R1 R2 R3 first post");
        irq_expect(1, 0, "R7 msi pass");
        check(last_vec == 6'd5, "R7 vector", 128'(last_vec), 128'd5);
    endtask

    task automatic t_intx_pass;
        cfg_msi_en = 1'b0;
        push(16'h0021, 15'h0002, 32'h1111_2222);
        push(16'h0022, 15'h7FFF, 32'h3333_4444);
        serve(16'h0021, 15'h0002, 32'h1111_2222, 3, "R8 order first");
        serve(16'h0022, 15'h7FFF, 32'h3333_4444, 0, "R8 order second");
        irq_expect(0, 1, "R7 legacy single pass");
    endtask

    task automatic t_full_wrap;
        bit idle = 1'b1;
        cfg_irq_en = 1'b0;
        push(16'h0031, 15'h0004, 32'h0000_0031);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (wr_req) idle = 1'b0;
        end
        check(idle, "R6 no write while full", 128'(!idle), 128'd0);
        cons_head = 12'd2;
        serve(16'h0031, 15'h0004, 32'h0000_0031, 0, "R6 resume after head move");
        check(bt == 0 && bph == 1'b0, "R5 tail wrap model", 128'(bt), 128'd0);
        push(16'h0032, 15'h0001, 32'h0000_0032);
        serve(16'h0032, 15'h0001, 32'h0000_0032, 0, "R5 phase inverted after wrap");
        irq_expect(0, 0, "R7 interrupts disabled");
    endtask

    task automatic t_fifo_backpressure;
        for (int i = 0; i < 4; i++) push(16'h0040 + 16'(i), 15'(i), 32'h4000 + 32'(i));
        check(!in_ready, "R8 ready low when fifo full", 128'(in_ready), 128'd0);
        check(!wr_req, "R6 held while full", 128'(wr_req), 128'd0);
        for (int i = 0; i < 4; i++) begin
            cons_head = QW'(bt);
            serve(16'h0040 + 16'(i), 15'(i), 32'h4000 + 32'(i), 0, "R8 fifo order");
        end
    endtask

    task automatic t_delete;
        bit idle = 1'b1;
        cons_head = 12'd2;
        push(16'h0051, 15'h0003, 32'h0000_0051);
        push(16'h0052, 15'h0003, 32'h0000_0052);
        del_q = 1'b1;
        @(negedge clk);
        del_q = 1'b0;
        cons_head = '0;
        cfg_base = 64'h0000_0002_0000_0000;
        cfg_esz_exp = 4'd5;
        bt = 0;
        bph = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (wr_req) idle = 1'b0;
        end
        check(idle, "R9 pending records dropped", 128'(!idle), 128'd0);
        check(in_ready, "R1 ready after delete", 128'(in_ready), 128'd1);
        push(16'h0061, 15'h0005, 32'h0000_0061);
        serve(16'h0061, 15'h0005, 32'h0000_0061, 0, "R1 post at base after delete");
        push(16'h0062, 15'h0006, 32'h0000_0062);
        serve(16'h0062, 15'h0006, 32'h0000_0062, 0, "R2 32-byte entry stride");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_msi_single();
        t_intx_pass();
        t_full_wrap();
        t_fifo_backpressure();
        t_delete();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule